// File: doc/BRIEF.md
# Auto-Incrementing Indirect Memory and Register Window

This block gives a host a narrow register port through which it can stream words into and out of a large internal SRAM, and reach a space of peripheral registers. The memory side uses two independent word pointers, one for reads and one for writes. The host loads a pointer once. Each access to the matching data register then moves that pointer on by one 32-bit word, so a block transfer needs no further address writes. Reads are prefetched. Loading the read pointer fetches the word at once, so the data register always holds the word the pointer names.

The peripheral side has its own read and write address registers. Each carries a register offset and a transfer size, given as the byte count minus one. A peripheral write drives byte enables that cover only the low-order bytes named by the count. A peripheral read returns zero in the bytes above that count.

The memory is a synchronous single-port SRAM with one cycle of read latency. The peripheral bus also returns read data one cycle after its strobe.

Top module: `idxwin_top`

## Requirements
- R1: After reset, hostRvalid, memEn and prphEn are low, and all four address registers read back as zero.
- R2: Host byte offsets decode as follows. Memory window: 0x0C read address, 0x10 write address, 0x18 write data, 0x1C read data. Peripheral window: 0x44 write address, 0x48 read address, 0x4C write data, 0x50 read data. Every read (hostRe with hostWe low) gives hostRvalid exactly one cycle later. A read of an unmapped offset returns zero. A write to any other offset, including a read-only offset, changes nothing and starts no bus cycle. When hostWe and hostRe are both high, only the write takes effect.
- R3: Loading the write address sets the write pointer to hostWdata[MEM_AW+1:2]. Each write-data access writes hostWdata to the SRAM at the write pointer in that same cycle (memEn=1, memWe=1), then advances the pointer by one word.
- R4: Loading the read address issues an SRAM read of that word in the same cycle. Each read-data access returns the currently prefetched word one cycle later, advances the read pointer by one word, and in the same cycle issues the SRAM read of the new pointer.
- R5: The two pointers are independent. Read-side accesses never change the write pointer, and write-side accesses never change the read pointer.
- R6: Both pointers wrap modulo MEM_DEPTH, so the word after MEM_DEPTH-1 is word 0.
- R7: Reading a memory address register returns the current pointer as a byte address ({pointer, 2'b00}), including all advances made since it was loaded.
- R8: A read-data access made after reset, before any read-address load, returns zero. The pointer still advances and a prefetch of word 1 is issued.
- R9: The peripheral address word carries the offset in bits [15:0] and the byte count minus one in bits [25:24]. A write-data access drives prphEn=1 and prphWe=1 with the write address offset, hostWdata, and prphBe set to 0001, 0011, 0111 or 1111 for counts 0 to 3.
- R10: A peripheral read-data access drives prphEn=1 and prphWe=0 with the read address offset and the matching byte enables. One cycle later, hostRdata carries prphRdata with every byte above the count forced to zero.
- R11: Reading a peripheral address register returns only bits [25:24] and [15:0] of the value last written. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWe | input | 1 | Host register write strobe |
| hostRe | input | 1 | Host register read strobe |
| hostAddr | input | 8 | Host register byte offset |
| hostWdata | input | 32 | Host write data |
| hostRvalid | output | 1 | Read response valid, one cycle after hostRe |
| hostRdata | output | 32 | Read response data |
| memEn | output | 1 | SRAM access enable |
| memWe | output | 1 | SRAM write enable |
| memAddr | output | MEM_AW | SRAM word address |
| memWdata | output | 32 | SRAM write data |
| memRdata | input | 32 | SRAM read data, one cycle after a read |
| prphEn | output | 1 | Peripheral access strobe |
| prphWe | output | 1 | Peripheral write enable |
| prphAddr | output | 16 | Peripheral register offset |
| prphBe | output | 4 | Peripheral byte enables |
| prphWdata | output | 32 | Peripheral write data |
| prphRdata | input | 32 | Peripheral read data, one cycle after a read strobe |

## Verification
The assertions take for granted that memRdata carries the addressed word in the cycle after a read strobe, and that it holds that word through a following write cycle. They assume the same one-cycle return for prphRdata and a power-of-two MEM_DEPTH. The bench keeps within these by attaching a behavioural SRAM and a peripheral register file that both answer exactly one cycle after the strobe. It drives one host request per cycle on the falling edge. It never writes the word that is sitting in the prefetch, so the stale-prefetch case stays outside every check.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;

  localparam int HOST_AW = 8;
  localparam int DATA_W  = 32;
  localparam int BE_W    = DATA_W / 8;
  localparam int PRPH_AW = 16;
  localparam int CNT_W   = 2;
  localparam int CNT_LSB = 24;

  localparam logic [HOST_AW-1:0] OFS_MEM_RADDR = 8'h0C;
  localparam logic [HOST_AW-1:0] OFS_MEM_WADDR = 8'h10;
  localparam logic [HOST_AW-1:0] OFS_MEM_WDATA = 8'h18;
  localparam logic [HOST_AW-1:0] OFS_MEM_RDATA = 8'h1C;
  localparam logic [HOST_AW-1:0] OFS_PR_WADDR  = 8'h44;
  localparam logic [HOST_AW-1:0] OFS_PR_RADDR  = 8'h48;
  localparam logic [HOST_AW-1:0] OFS_PR_WDATA  = 8'h4C;
  localparam logic [HOST_AW-1:0] OFS_PR_RDATA  = 8'h50;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MRADDR,
    SEL_MWADDR,
    SEL_MRDATA,
    SEL_PRWADDR,
    SEL_PRRADDR,
    SEL_PRDATA
  } readSel_e;

  typedef struct packed {
    logic     ldMemRaddr;
    logic     ldMemWaddr;
    logic     memWrData;
    logic     memRdData;
    logic     ldPrWaddr;
    logic     ldPrRaddr;
    logic     prWrData;
    logic     prRdData;
    logic     rdAny;
    readSel_e readSel;
  } winStrobe_t;

  typedef struct packed {
    logic [CNT_W-1:0]   cnt;
    logic [PRPH_AW-1:0] ofs;
  } prphAddr_t;

  function automatic logic [BE_W-1:0] beFromCount(input logic [CNT_W-1:0] c);
    logic [BE_W-1:0] be;
    be = '0;
    for (int i = 0; i < BE_W; i++) begin
      if (i <= int'(c)) be[i] = 1'b1;
    end
    return be;
  endfunction

  function automatic logic [DATA_W-1:0] maskFromBe(input logic [BE_W-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < BE_W; i++) begin
      m[8*i +: 8] = {8{be[i]}};
    end
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] packPrph(input prphAddr_t p);
    logic [DATA_W-1:0] v;
    v = '0;
    v[CNT_LSB +: CNT_W]  = p.cnt;
    v[PRPH_AW-1:0]       = p.ofs;
    return v;
  endfunction

  function automatic prphAddr_t unpackPrph(input logic [DATA_W-1:0] v);
    prphAddr_t p;
    p.cnt = v[CNT_LSB +: CNT_W];
    p.ofs = v[PRPH_AW-1:0];
    return p;
  endfunction

endpackage

// File: rtl/idxwin_ctrl.sv
module idxwin_ctrl
  import idxwin_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWe,
  input  logic               hostRe,
  input  logic [HOST_AW-1:0] hostAddr,
  output winStrobe_t         strobe
);

  logic wrReq;
  logic rdReq;

  assign wrReq = hostWe;
  assign rdReq = hostRe && !hostWe;

  always_comb begin
    strobe         = '0;
    strobe.readSel = SEL_NONE;
    strobe.rdAny   = rdReq;
    if (wrReq) begin
      case (hostAddr)
        OFS_MEM_RADDR: strobe.ldMemRaddr = 1'b1;
        OFS_MEM_WADDR: strobe.ldMemWaddr = 1'b1;
        OFS_MEM_WDATA: strobe.memWrData  = 1'b1;
        OFS_PR_WADDR:  strobe.ldPrWaddr  = 1'b1;
        OFS_PR_RADDR:  strobe.ldPrRaddr  = 1'b1;
        OFS_PR_WDATA:  strobe.prWrData   = 1'b1;
        default:       ;
      endcase
    end else if (rdReq) begin
      case (hostAddr)
        OFS_MEM_RADDR: strobe.readSel = SEL_MRADDR;
        OFS_MEM_WADDR: strobe.readSel = SEL_MWADDR;
        OFS_MEM_RDATA: begin
          strobe.readSel   = SEL_MRDATA;
          strobe.memRdData = 1'b1;
        end
        OFS_PR_WADDR:  strobe.readSel = SEL_PRWADDR;
        OFS_PR_RADDR:  strobe.readSel = SEL_PRRADDR;
        OFS_PR_RDATA: begin
          strobe.readSel  = SEL_PRDATA;
          strobe.prRdData = 1'b1;
        end
        default:       ;
      endcase
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.ldMemRaddr, strobe.ldMemWaddr, strobe.memWrData, strobe.memRdData,
                strobe.ldPrWaddr, strobe.ldPrRaddr, strobe.prWrData, strobe.prRdData}) <= 1); // R2

  AST_READ_NEEDS_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.memRdData || strobe.prRdData) |-> (hostRe && !hostWe)); // R2

endmodule

// File: rtl/idxwin_dpath.sv
module idxwin_dpath
  import idxwin_pkg::*;
#(
  parameter int MEM_DEPTH = 256,
  parameter int MEM_AW    = $clog2(MEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  winStrobe_t         strobe,
  input  logic [DATA_W-1:0]  hostWdata,
  output logic               hostRvalid,
  output logic [DATA_W-1:0]  hostRdata,
  output logic               memEn,
  output logic               memWe,
  output logic [MEM_AW-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  input  logic [DATA_W-1:0]  memRdata,
  output logic               prphEn,
  output logic               prphWe,
  output logic [PRPH_AW-1:0] prphAddr,
  output logic [BE_W-1:0]    prphBe,
  output logic [DATA_W-1:0]  prphWdata,
  input  logic [DATA_W-1:0]  prphRdata
);

  localparam logic [MEM_AW-1:0] PTR_ONE = MEM_AW'(1);

  logic [MEM_AW-1:0] rdPtr;
  logic [MEM_AW-1:0] wrPtr;
  logic [MEM_AW-1:0] hostIdx;
  logic [MEM_AW-1:0] rdPtrNext;
  logic [DATA_W-1:0] rdBuf;
  logic              prefetchPending;
  logic [DATA_W-1:0] curWord;
  prphAddr_t         prWr;
  prphAddr_t         prRd;
  logic              rspFromPrph;
  logic [DATA_W-1:0] rspMask;
  logic [DATA_W-1:0] rspReg;

  assign hostIdx   = hostWdata[MEM_AW+1:2];
  assign rdPtrNext = rdPtr + PTR_ONE;
  assign curWord   = prefetchPending ? memRdata : rdBuf;

  // SRAM port: at most one action strobe is active per cycle.
  always_comb begin
    memEn    = 1'b0;
    memWe    = 1'b0;
    memAddr  = rdPtr;
    memWdata = hostWdata;
    if (strobe.memWrData) begin
      memEn   = 1'b1;
      memWe   = 1'b1;
      memAddr = wrPtr;
    end else if (strobe.ldMemRaddr) begin
      memEn   = 1'b1;
      memAddr = hostIdx;
    end else if (strobe.memRdData) begin
      memEn   = 1'b1;
      memAddr = rdPtrNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr           <= '0;
      wrPtr           <= '0;
      rdBuf           <= '0;
      prefetchPending <= 1'b0;
    end else begin
      if (strobe.ldMemRaddr)     rdPtr <= hostIdx;
      else if (strobe.memRdData) rdPtr <= rdPtrNext;
      if (strobe.ldMemWaddr)     wrPtr <= hostIdx;
      else if (strobe.memWrData) wrPtr <= wrPtr + PTR_ONE;
      if (prefetchPending)       rdBuf <= memRdata;
      prefetchPending <= strobe.ldMemRaddr || strobe.memRdData;
    end
  end

  // Peripheral window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prWr <= '0;
      prRd <= '0;
    end else begin
      if (strobe.ldPrWaddr) prWr <= unpackPrph(hostWdata);
      if (strobe.ldPrRaddr) prRd <= unpackPrph(hostWdata);
    end
  end

  assign prphEn    = strobe.prWrData || strobe.prRdData;
  assign prphWe    = strobe.prWrData;
  assign prphAddr  = strobe.prWrData ? prWr.ofs : prRd.ofs;
  assign prphBe    = beFromCount(strobe.prWrData ? prWr.cnt : prRd.cnt);
  assign prphWdata = hostWdata;

  // Read response, one cycle after the request.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRvalid  <= 1'b0;
      rspFromPrph <= 1'b0;
      rspMask     <= '0;
      rspReg      <= '0;
    end else begin
      hostRvalid  <= strobe.rdAny;
      rspFromPrph <= (strobe.readSel == SEL_PRDATA);
      rspMask     <= maskFromBe(beFromCount(prRd.cnt));
      case (strobe.readSel)
        SEL_MRADDR:  rspReg <= DATA_W'({rdPtr, 2'b00});
        SEL_MWADDR:  rspReg <= DATA_W'({wrPtr, 2'b00});
        SEL_MRDATA:  rspReg <= curWord;
        SEL_PRWADDR: rspReg <= packPrph(prWr);
        SEL_PRRADDR: rspReg <= packPrph(prRd);
        default:     rspReg <= '0;
      endcase
    end
  end

  assign hostRdata = rspFromPrph ? (prphRdata & rspMask) : rspReg;

  AST_WPTR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |=> (wrPtr == MEM_AW'($past(memAddr) + PTR_ONE))); // R3

  AST_WPTR_QUIET_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.ldMemRaddr || strobe.memRdData) && !strobe.ldMemWaddr && !strobe.memWrData)
      |=> $stable(wrPtr)); // R5

  AST_RPTR_QUIET_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.ldMemWaddr || strobe.memWrData) && !strobe.ldMemRaddr && !strobe.memRdData)
      |=> $stable(rdPtr)); // R5

  AST_PREFETCH_FROM_READ: assert property (@(posedge clk) disable iff (!rstN)
    prefetchPending |-> $past(memEn && !memWe)); // R4

  AST_PRPH_BE_LOW_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    prphEn |-> (prphBe[0] && ((prphBe & (prphBe + 4'd1)) == 4'd0))); // R9

endmodule

// File: rtl/idxwin_top.sv
module idxwin_top
  import idxwin_pkg::*;
#(
  parameter int MEM_DEPTH = 256,
  parameter int MEM_AW    = $clog2(MEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWe,
  input  logic               hostRe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0]  hostWdata,
  output logic               hostRvalid,
  output logic [DATA_W-1:0]  hostRdata,
  output logic               memEn,
  output logic               memWe,
  output logic [MEM_AW-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  input  logic [DATA_W-1:0]  memRdata,
  output logic               prphEn,
  output logic               prphWe,
  output logic [PRPH_AW-1:0] prphAddr,
  output logic [BE_W-1:0]    prphBe,
  output logic [DATA_W-1:0]  prphWdata,
  input  logic [DATA_W-1:0]  prphRdata
);

  winStrobe_t strobe;

  idxwin_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostWe   (hostWe),
    .hostRe   (hostRe),
    .hostAddr (hostAddr),
    .strobe   (strobe)
  );

  idxwin_dpath #(
    .MEM_DEPTH (MEM_DEPTH),
    .MEM_AW    (MEM_AW)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hostWdata  (hostWdata),
    .hostRvalid (hostRvalid),
    .hostRdata  (hostRdata),
    .memEn      (memEn),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRdata   (memRdata),
    .prphEn     (prphEn),
    .prphWe     (prphWe),
    .prphAddr   (prphAddr),
    .prphBe     (prphBe),
    .prphWdata  (prphWdata),
    .prphRdata  (prphRdata)
  );

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    hostRvalid |-> $past(hostRe && !hostWe)); // R2

  AST_NO_BUS_ON_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!hostWe && !hostRe) |-> (!memEn && !prphEn)); // R2

endmodule

// File: tb/idxwin_top_tb.sv
`timescale 1ns/1ps
module idxwin_top_tb;

  localparam int D  = 16;
  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic        hostRe = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic        hostRvalid;
  logic [31:0] hostRdata;
  logic        memEn, memWe;
  logic [AW-1:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata;
  logic        prphEn, prphWe;
  logic [15:0] prphAddr;
  logic [3:0]  prphBe;
  logic [31:0] prphWdata;
  logic [31:0] prphRdata;

  always #4 clk = ~clk;

  idxwin_top #(.MEM_DEPTH(D)) u_dut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostRe(hostRe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRvalid(hostRvalid), .hostRdata(hostRdata),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .prphEn(prphEn), .prphWe(prphWe), .prphAddr(prphAddr), .prphBe(prphBe),
    .prphWdata(prphWdata), .prphRdata(prphRdata)
  );

  // Behavioural SRAM and peripheral register file, one-cycle read latency.
  logic [31:0] ram [0:D-1];
  logic [31:0] prRegs [0:15];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < D; i++) ram[i] <= 32'hDEAD_0000 | i;
      memRdata <= '0;
    end else if (memEn) begin
      if (memWe) ram[memAddr] <= memWdata;
      else       memRdata <= ram[memAddr];
    end
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) prRegs[i] <= 32'hF0E0_D000 | i;
      prphRdata <= '0;
    end else if (prphEn) begin
      if (prphWe) begin
        for (int b = 0; b < 4; b++)
          if (prphBe[b]) prRegs[prphAddr[5:2]][8*b +: 8] <= prphWdata[8*b +: 8];
      end else begin
        prphRdata <= prRegs[prphAddr[5:2]];
      end
    end
  end

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  // Reference model state.
  int          mRptr = 0, mWptr = 0;
  logic [31:0] mPref = '0;
  logic [15:0] mPrWofs = '0, mPrRofs = '0;
  logic [1:0]  mPrWcnt = '0, mPrRcnt = '0;
  bit          expValid = 0;
  logic [31:0] expData = '0;
  string       expTag = "R1";

  function automatic logic [3:0] beOf(input logic [1:0] c);
    case (c)
      2'd0: return 4'b0001;
      2'd1: return 4'b0011;
      2'd2: return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] byteMask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = be[b] ? 8'hFF : 8'h00;
    return m;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag, input bit we, input bit re,
                     input logic [7:0] a, input logic [31:0] d);
    bit eEn, eWe, pEn, pWe;
    int eAddr;
    logic [15:0] pAddr;
    logic [3:0]  pBe;
    bit nValid;
    logic [31:0] nData;
    @(negedge clk);
    hostWe = we; hostRe = re; hostAddr = a; hostWdata = d;
    #1;
    chk({expTag, " rvalid"}, 32'(hostRvalid), 32'(expValid));
    if (expValid) chk({expTag, " rdata"}, hostRdata, expData);
    eEn = 0; eWe = 0; eAddr = 0; pEn = 0; pWe = 0; pAddr = '0; pBe = '0;
    nValid = 0; nData = '0;
    if (we) begin
      case (a)
        8'h0C: begin mRptr = (d >> 2) % D; eEn = 1; eAddr = mRptr; mPref = ram[mRptr]; end
        8'h10: mWptr = (d >> 2) % D;
        8'h18: begin eEn = 1; eWe = 1; eAddr = mWptr; mWptr = (mWptr + 1) % D; end
        8'h44: begin mPrWofs = d[15:0]; mPrWcnt = d[25:24]; end
        8'h48: begin mPrRofs = d[15:0]; mPrRcnt = d[25:24]; end
        8'h4C: begin pEn = 1; pWe = 1; pAddr = mPrWofs; pBe = beOf(mPrWcnt); end
        default: ;
      endcase
    end else if (re) begin
      nValid = 1;
      case (a)
        8'h0C: nData = 32'(mRptr * 4);
        8'h10: nData = 32'(mWptr * 4);
        8'h1C: begin
          nData = mPref; mRptr = (mRptr + 1) % D;
          eEn = 1; eAddr = mRptr; mPref = ram[mRptr];
        end
        8'h44: nData = {6'b0, mPrWcnt, 8'b0, mPrWofs};
        8'h48: nData = {6'b0, mPrRcnt, 8'b0, mPrRofs};
        8'h50: begin
          pEn = 1; pAddr = mPrRofs; pBe = beOf(mPrRcnt);
          nData = prRegs[mPrRofs[5:2]] & byteMask(beOf(mPrRcnt));
        end
        default: nData = '0;
      endcase
    end
    chk({tag, " memEn"}, 32'(memEn), 32'(eEn));
    if (eEn) begin
      chk({tag, " memWe"}, 32'(memWe), 32'(eWe));
      chk({tag, " memAddr"}, 32'(memAddr), 32'(eAddr));
      if (eWe) chk({tag, " memWdata"}, memWdata, d);
    end
    chk({tag, " prphEn"}, 32'(prphEn), 32'(pEn));
    if (pEn) begin
      chk({tag, " prphWe"}, 32'(prphWe), 32'(pWe));
      chk({tag, " prphAddr"}, 32'(prphAddr), 32'(pAddr));
      chk({tag, " prphBe"}, 32'(prphBe), 32'(pBe));
      if (pWe) chk({tag, " prphWdata"}, prphWdata, d);
    end
    expValid = nValid; expData = nData; expTag = tag;
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] d);
    cyc(tag, 1, 0, a, d);
  endtask
  task automatic rd(input string tag, input logic [7:0] a);
    cyc(tag, 0, 1, a, '0);
  endtask
  task automatic idle(input string tag);
    cyc(tag, 0, 0, 8'h00, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk("R1 rvalid", 32'(hostRvalid), 32'd0);
    chk("R1 memEn", 32'(memEn), 32'd0);
    chk("R1 prphEn", 32'(prphEn), 32'd0);
    rd("R1", 8'h0C); rd("R1", 8'h10); rd("R1", 8'h44); rd("R1", 8'h48);
    // R8: data read before any load returns zero, prefetches word 1
    rd("R8", 8'h1C);
    rd("R8", 8'h1C);
    // R3: stream writes from word 0
    wr("R3", 8'h10, 32'h0000_0000);
    for (int i = 0; i < 8; i++) wr("R3", 8'h18, 32'hA500_0000 + i);
    rd("R7", 8'h10);
    // R4: prefetching reads, back to back
    wr("R4", 8'h0C, 32'h0000_0004);
    for (int i = 0; i < 5; i++) rd("R4", 8'h1C);
    rd("R7", 8'h0C);
    // R5: interleaved independent pointers
    wr("R5", 8'h10, 32'h0000_0028);
    for (int i = 0; i < 3; i++) begin
      wr("R5", 8'h18, 32'h5A00_0000 + i);
      rd("R5", 8'h1C);
    end
    rd("R5", 8'h10); rd("R5", 8'h0C);
    // R6: wrap of both pointers
    wr("R6", 8'h10, 32'h0000_0038);
    for (int i = 0; i < 4; i++) wr("R6", 8'h18, 32'hC000_0000 + i);
    rd("R6", 8'h10);
    wr("R6", 8'h0C, 32'h0000_003C);
    for (int i = 0; i < 3; i++) rd("R6", 8'h1C);
    rd("R7", 8'h0C);
    // R9: peripheral writes with each byte count
    wr("R9", 8'h44, 32'h0300_0008); wr("R9", 8'h4C, 32'hA1B2_C3D4);
    wr("R9", 8'h44, 32'h0000_000C); wr("R9", 8'h4C, 32'h1122_3344);
    wr("R9", 8'h44, 32'h0100_0010); wr("R9", 8'h4C, 32'h5566_7788);
    wr("R9", 8'h44, 32'h0200_0014); wr("R9", 8'h4C, 32'h99AA_BBCC);
    // R10: peripheral reads, full and partial
    wr("R10", 8'h48, 32'h0300_0008); rd("R10", 8'h50);
    wr("R10", 8'h48, 32'h0300_000C); rd("R10", 8'h50);
    wr("R10", 8'h48, 32'h0100_0010); rd("R10", 8'h50);
    wr("R10", 8'h48, 32'h0200_0014); rd("R10", 8'h50);
    wr("R10", 8'h48, 32'h0000_0018); rd("R10", 8'h50);
    // R11: address register readback keeps only offset and count
    wr("R11", 8'h44, 32'hFFFF_FFFF); rd("R11", 8'h44);
    wr("R11", 8'h48, 32'hFCFF_1234); rd("R11", 8'h48);
    // R2: unmapped and read-only offsets, write priority
    wr("R2", 8'h1C, 32'h0000_0000);
    wr("R2", 8'h50, 32'h0000_0000);
    wr("R2", 8'h20, 32'hFFFF_FFFF);
    rd("R2", 8'h20);
    cyc("R2", 1, 1, 8'h10, 32'h0000_0020);
    rd("R2", 8'h10);
    cyc("R2", 1, 1, 8'h1C, 32'h0);
    rd("R2", 8'h0C);
    idle("R2"); idle("R2");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule